// File: doc/BRIEF.md
# Periodic Queue-Head Retire Controller

This block owns the scheduling status of one periodic queue head that drives split transactions through a hub translator. Each time the scheduler strobes an evaluation it supplies the current micro-frame index. The block then chooses one of four outcomes: issue a start-split, issue a complete-split, retire the queue head, or do nothing. It reports the choice as one-cycle pulses, together with a status write-back.

Software stops the queue head safely by raising an inactivate-on-next-transaction flag (called "I" below). At the next evaluation that finds the split state at the start position, the block drops Active instead of starting a new split. Once Active is low, software may replace the start and complete masks. It then reactivates the queue head with a guarded sequence of three writes: raise Halted, clear I, then raise Active and clear Halted in one write. The block rejects any attempt to raise Active while I is still set.

Top module: `pqh_retire_ctrl`

## Requirements
- R1: An evaluation that finds Active low produces no start-split, complete-split, queue-advance or write-back pulse, and changes no state.
- R2: An evaluation that finds I set never produces a queue-advance pulse.
- R3: An evaluation that finds Active high, Halted low, I set and the split state at start (qhSplitCmp=0) clears Active, whatever the start mask holds. It pulses wbValid with wbActive=0 and produces no complete-split or advance pulse.
- R4: In the retire case of R3, no start-split is issued even when the start-mask bit selected by uFrame is set.
- R5: The write-back outputs wbActive and wbSplitCmp take the post-evaluation Active and split state only in a cycle that pulses wbValid. wbValid pulses exactly when a retire, a start-split or a complete-split happens. Otherwise wbActive and wbSplitCmp hold their values.
- R6: A software write that sets Active while I is set (before the write) leaves Active unchanged. Clearing Active is always accepted. An evaluation that retires wins over a same-cycle software set.
- R7: An evaluation that finds Halted set issues no split and no advance, even with Active set.
- R8: With Active high, Halted low, I clear and the split state at start, an evaluation whose start-mask bit uFrame is 1 pulses ssIssue and moves the split state to complete (qhSplitCmp=1).
- R9: In the complete state, an evaluation whose complete-mask bit uFrame is 1 pulses csIssue. If no higher complete-mask bit is set, the split state returns to start. qAdvance pulses with that final complete-split only when I is clear.
- R10: Mask writes (swWrSMask, swWrCMask) take effect only when Active is low before the write. Otherwise they are ignored.
- R11: After reset, every status bit, both masks and all output pulses are 0, and the split state is start.
- R12: After the writes "set Halted", "clear I", "set Active and clear Halted", the queue head shows Active=1, Halted=0 and I=0, and it schedules again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evalStb | input | 1 | Evaluate the queue head in this cycle |
| uFrame | input | 3 | Current micro-frame index |
| swWrActive | input | 1 | Software write enable for Active |
| swActiveVal | input | 1 | Value written to Active |
| swWrHalted | input | 1 | Software write enable for Halted |
| swHaltedVal | input | 1 | Value written to Halted |
| swWrInact | input | 1 | Software write enable for I |
| swInactVal | input | 1 | Value written to I |
| swWrSMask | input | 1 | Software write enable for start mask |
| swSMaskVal | input | 8 | Start mask value |
| swWrCMask | input | 1 | Software write enable for complete mask |
| swCMaskVal | input | 8 | Complete mask value |
| ssIssue | output | 1 | Start-split issue pulse |
| csIssue | output | 1 | Complete-split issue pulse |
| qAdvance | output | 1 | Queue-advance pulse |
| wbValid | output | 1 | Status write-back pulse |
| wbActive | output | 1 | Active value written back |
| wbSplitCmp | output | 1 | Split state written back (1 = complete) |
| qhActive | output | 1 | Current Active bit |
| qhHalted | output | 1 | Current Halted bit |
| qhInact | output | 1 | Current I bit |
| qhSplitCmp | output | 1 | Current split state (1 = complete) |
| qhSMask | output | 8 | Current start mask |
| qhCMask | output | 8 | Current complete mask |

## Verification
The bench raises I in the middle of a split and checks that the remaining complete-splits still go out without an advance. A design that retired on the spot would abandon the split, and one that ignored I would advance the queue. It raises I in a micro-frame whose start bit is set, where a faulty design issues a start-split that software never expects. It also applies the reactivation writes out of order, so that a controller accepting Active while I is still set reactivates too early. Long random runs mix evaluations with stray writes, including mask writes while active, which a design without the Active guard would take mid-schedule.

// File: rtl/pqh_pkg.sv
package pqh_pkg;

  typedef enum logic {
    SPLIT_START    = 1'b0,
    SPLIT_COMPLETE = 1'b1
  } splitState_e;

  typedef struct packed {
    logic retire;
    logic issueStart;
    logic issueComplete;
    logic lastComplete;
    logic advance;
    logic writeBack;
  } ctrlStb_t;

endpackage

// File: rtl/pqh_control.sv
module pqh_control
  import pqh_pkg::*;
#(
  parameter int NUM_UF = 8,
  localparam int UF_W = $clog2(NUM_UF)
) (
  input  logic              evalStb,
  input  logic [UF_W-1:0]   uFrame,
  input  logic              active,
  input  logic              halted,
  input  logic              inact,
  input  splitState_e       split,
  input  logic [NUM_UF-1:0] sMask,
  input  logic [NUM_UF-1:0] cMask,
  output ctrlStb_t          stb
);

  logic [NUM_UF-1:0] laterMask;
  logic evalLive;
  logic startBit;
  logic completeBit;
  logic moreComplete;

  always_comb begin
    for (int i = 0; i < NUM_UF; i++) begin
      laterMask[i] = (i > int'(uFrame));
    end
  end

  assign evalLive     = evalStb && active && !halted;
  assign startBit     = sMask[uFrame];
  assign completeBit  = cMask[uFrame];
  assign moreComplete = |(cMask & laterMask);

  always_comb begin
    stb = '0;
    if (evalLive) begin
      if (split == SPLIT_START) begin
        stb.retire     = inact;
        stb.issueStart = !inact && startBit;
      end else begin
        stb.issueComplete = completeBit;
        stb.lastComplete  = completeBit && !moreComplete;
      end
    end
    stb.advance   = stb.lastComplete && !inact;
    stb.writeBack = stb.retire || stb.issueStart || stb.issueComplete;
  end

endmodule

// File: rtl/pqh_datapath.sv
module pqh_datapath
  import pqh_pkg::*;
#(
  parameter int NUM_UF = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              swWrActive,
  input  logic              swActiveVal,
  input  logic              swWrHalted,
  input  logic              swHaltedVal,
  input  logic              swWrInact,
  input  logic              swInactVal,
  input  logic              swWrSMask,
  input  logic [NUM_UF-1:0] swSMaskVal,
  input  logic              swWrCMask,
  input  logic [NUM_UF-1:0] swCMaskVal,
  output logic              active,
  output logic              halted,
  output logic              inact,
  output splitState_e       split,
  output logic [NUM_UF-1:0] sMask,
  output logic [NUM_UF-1:0] cMask,
  output logic              ssIssue,
  output logic              csIssue,
  output logic              qAdvance,
  output logic              wbValid,
  output logic              wbActive,
  output logic              wbSplitCmp
);

  logic        activeNext;
  splitState_e splitNext;

  always_comb begin
    activeNext = active;
    if (swWrActive) begin
      activeNext = swActiveVal ? (inact ? active : 1'b1) : 1'b0;
    end
    if (stb.retire) begin
      activeNext = 1'b0;
    end
  end

  always_comb begin
    splitNext = split;
    if (stb.issueStart) begin
      splitNext = SPLIT_COMPLETE;
    end else if (stb.lastComplete) begin
      splitNext = SPLIT_START;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      halted <= 1'b0;
      inact  <= 1'b0;
      split  <= SPLIT_START;
      sMask  <= '0;
      cMask  <= '0;
    end else begin
      active <= activeNext;
      split  <= splitNext;
      if (swWrHalted) halted <= swHaltedVal;
      if (swWrInact)  inact  <= swInactVal;
      if (swWrSMask && !active) sMask <= swSMaskVal;
      if (swWrCMask && !active) cMask <= swCMaskVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssIssue    <= 1'b0;
      csIssue    <= 1'b0;
      qAdvance   <= 1'b0;
      wbValid    <= 1'b0;
      wbActive   <= 1'b0;
      wbSplitCmp <= 1'b0;
    end else begin
      ssIssue  <= stb.issueStart;
      csIssue  <= stb.issueComplete;
      qAdvance <= stb.advance;
      wbValid  <= stb.writeBack;
      if (stb.writeBack) begin
        wbActive   <= activeNext;
        wbSplitCmp <= (splitNext == SPLIT_COMPLETE);
      end
    end
  end

endmodule

// File: rtl/pqh_retire_ctrl.sv
module pqh_retire_ctrl
  import pqh_pkg::*;
#(
  parameter int NUM_UF = 8,
  localparam int UF_W = $clog2(NUM_UF)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalStb,
  input  logic [UF_W-1:0]   uFrame,
  input  logic              swWrActive,
  input  logic              swActiveVal,
  input  logic              swWrHalted,
  input  logic              swHaltedVal,
  input  logic              swWrInact,
  input  logic              swInactVal,
  input  logic              swWrSMask,
  input  logic [NUM_UF-1:0] swSMaskVal,
  input  logic              swWrCMask,
  input  logic [NUM_UF-1:0] swCMaskVal,
  output logic              ssIssue,
  output logic              csIssue,
  output logic              qAdvance,
  output logic              wbValid,
  output logic              wbActive,
  output logic              wbSplitCmp,
  output logic              qhActive,
  output logic              qhHalted,
  output logic              qhInact,
  output logic              qhSplitCmp,
  output logic [NUM_UF-1:0] qhSMask,
  output logic [NUM_UF-1:0] qhCMask
);

  ctrlStb_t    ctrlStb;
  splitState_e splitQ;

  pqh_control #(.NUM_UF(NUM_UF)) u_control (
    .evalStb (evalStb),
    .uFrame  (uFrame),
    .active  (qhActive),
    .halted  (qhHalted),
    .inact   (qhInact),
    .split   (splitQ),
    .sMask   (qhSMask),
    .cMask   (qhCMask),
    .stb     (ctrlStb)
  );

  pqh_datapath #(.NUM_UF(NUM_UF)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (ctrlStb),
    .swWrActive  (swWrActive),
    .swActiveVal (swActiveVal),
    .swWrHalted  (swWrHalted),
    .swHaltedVal (swHaltedVal),
    .swWrInact   (swWrInact),
    .swInactVal  (swInactVal),
    .swWrSMask   (swWrSMask),
    .swSMaskVal  (swSMaskVal),
    .swWrCMask   (swWrCMask),
    .swCMaskVal  (swCMaskVal),
    .active      (qhActive),
    .halted      (qhHalted),
    .inact       (qhInact),
    .split       (splitQ),
    .sMask       (qhSMask),
    .cMask       (qhCMask),
    .ssIssue     (ssIssue),
    .csIssue     (csIssue),
    .qAdvance    (qAdvance),
    .wbValid     (wbValid),
    .wbActive    (wbActive),
    .wbSplitCmp  (wbSplitCmp)
  );

  assign qhSplitCmp = (splitQ == SPLIT_COMPLETE);

endmodule

// File: rtl/pqh_retire_chk.sv
module pqh_retire_chk #(
  parameter int NUM_UF = 8,
  localparam int UF_W = $clog2(NUM_UF)
) (
  input logic              clk,
  input logic              rstN,
  input logic              evalStb,
  input logic [UF_W-1:0]   uFrame,
  input logic              ssIssue,
  input logic              csIssue,
  input logic              qAdvance,
  input logic              wbValid,
  input logic              qhActive,
  input logic              qhHalted,
  input logic              qhInact,
  input logic              qhSplitCmp,
  input logic [NUM_UF-1:0] qhSMask,
  input logic [NUM_UF-1:0] qhCMask
);

  logic retireCase;
  logic startCase;
  assign retireCase = evalStb && qhActive && !qhHalted && qhInact && !qhSplitCmp;
  assign startCase  = evalStb && qhActive && !qhHalted && !qhInact && !qhSplitCmp && qhSMask[uFrame];

  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    evalStb && !qhActive |=> !ssIssue && !csIssue && !qAdvance && !wbValid); // R1
  AST_NO_ADVANCE_WITH_I: assert property (@(posedge clk) disable iff (!rstN)
    evalStb && qhInact |=> !qAdvance); // R2
  AST_RETIRE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    retireCase |=> !qhActive && wbValid && !csIssue && !qAdvance); // R3
  AST_NO_START_ON_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    retireCase |=> !ssIssue); // R4
  AST_SET_NEEDS_I_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qhActive) |-> !$past(qhInact)); // R6
  AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    evalStb && qhHalted |=> !ssIssue && !csIssue && !qAdvance); // R7
  AST_START_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    startCase |=> ssIssue && qhSplitCmp); // R8
  AST_SPLIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(ssIssue && csIssue)); // R9
  AST_ADVANCE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    qAdvance |-> csIssue && !qhSplitCmp); // R9
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(qhActive) |-> $stable(qhSMask) && $stable(qhCMask)); // R10

endmodule

bind pqh_retire_ctrl pqh_retire_chk #(.NUM_UF(NUM_UF)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evalStb    (evalStb),
  .uFrame     (uFrame),
  .ssIssue    (ssIssue),
  .csIssue    (csIssue),
  .qAdvance   (qAdvance),
  .wbValid    (wbValid),
  .qhActive   (qhActive),
  .qhHalted   (qhHalted),
  .qhInact    (qhInact),
  .qhSplitCmp (qhSplitCmp),
  .qhSMask    (qhSMask),
  .qhCMask    (qhCMask)
);

// File: tb/pqh_retire_ctrl_tb.sv
module pqh_retire_ctrl_tb;

  logic clk = 1'b0;
  logic rstN;
  logic evalStb;
  logic [2:0] uFrame;
  logic swWrActive, swActiveVal, swWrHalted, swHaltedVal, swWrInact, swInactVal;
  logic swWrSMask, swWrCMask;
  logic [7:0] swSMaskVal, swCMaskVal;
  logic ssIssue, csIssue, qAdvance, wbValid, wbActive, wbSplitCmp;
  logic qhActive, qhHalted, qhInact, qhSplitCmp;
  logic [7:0] qhSMask, qhCMask;

  int checks = 0;
  int failures = 0;

  logic mAct, mHalt, mInact, mCmp;
  logic [7:0] mS, mC;
  logic eSs, eCs, eAdv, eWb, eWbAct, eWbCmp;

  always #5 clk = ~clk;

  pqh_retire_ctrl u_dut (.*);

  task automatic clearIns();
    evalStb = 0; uFrame = 0;
    swWrActive = 0; swActiveVal = 0; swWrHalted = 0; swHaltedVal = 0;
    swWrInact = 0; swInactVal = 0; swWrSMask = 0; swSMaskVal = 0;
    swWrCMask = 0; swCMaskVal = 0;
  endtask

  task automatic modelStep(output string tag);
    logic live, retire, ss, cs, last, newAct, newCmp;
    live   = evalStb && mAct && !mHalt;
    retire = live && mInact && !mCmp;
    ss     = live && !mInact && !mCmp && mS[uFrame];
    cs     = live && mCmp && mC[uFrame];
    last   = cs && ((mC >> uFrame) == 8'h01);
    if (!evalStb) tag = "R6_R10_write";
    else if (!mAct) tag = "R1";
    else if (mHalt) tag = "R7";
    else if (retire) tag = "R3";
    else if (!mCmp) tag = "R8";
    else tag = "R9";
    newAct = mAct;
    if (swWrActive) newAct = swActiveVal ? (mInact ? mAct : 1'b1) : 1'b0;
    if (retire) newAct = 1'b0;
    newCmp = ss ? 1'b1 : (last ? 1'b0 : mCmp);
    if (swWrSMask && !mAct) mS = swSMaskVal;
    if (swWrCMask && !mAct) mC = swCMaskVal;
    if (swWrHalted) mHalt = swHaltedVal;
    if (swWrInact) mInact = swInactVal;
    eSs = ss; eCs = cs; eAdv = last && !mInact_pre(live, retire);
    eAdv = last && !preInact;
    eWb = retire || ss || cs;
    if (eWb) begin eWbAct = newAct; eWbCmp = newCmp; end
    mAct = newAct; mCmp = newCmp;
  endtask

  logic preInact;
  function automatic logic mInact_pre(logic a, logic b);
    return preInact & (a | b | 1'b1);
  endfunction

  task automatic tick(input string why);
    string tag;
    logic [25:0] act, exp;
    preInact = mInact;
    modelStep(tag);
    if (why != "") tag = why;
    @(posedge clk);
    #1;
    act = {ssIssue, csIssue, qAdvance, wbValid, wbActive, wbSplitCmp,
           qhActive, qhHalted, qhInact, qhSplitCmp, qhSMask, qhCMask};
    exp = {eSs, eCs, eAdv, eWb, eWbAct, eWbCmp, mAct, mHalt, mInact, mCmp, mS, mC};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
    clearIns();
  endtask

  task automatic ev(input logic [2:0] uf, input string why);
    evalStb = 1; uFrame = uf;
    tick(why);
  endtask

  task automatic wrStatus(input logic wa, input logic va, input logic wh, input logic vh,
                          input logic wi, input logic vi, input string why);
    swWrActive = wa; swActiveVal = va; swWrHalted = wh; swHaltedVal = vh;
    swWrInact = wi; swInactVal = vi;
    tick(why);
  endtask

  task automatic wrMasks(input logic [7:0] s, input logic [7:0] c, input string why);
    swWrSMask = 1; swSMaskVal = s; swWrCMask = 1; swCMaskVal = c;
    tick(why);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [2:0] ufCnt;
    void'($urandom(32'd5150));
    clearIns();
    mAct = 0; mHalt = 0; mInact = 0; mCmp = 0; mS = 0; mC = 0;
    eSs = 0; eCs = 0; eAdv = 0; eWb = 0; eWbAct = 0; eWbCmp = 0; preInact = 0;
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    tick("R11_reset");

    // inactive evaluation does nothing
    ev(3'd0, "R1_idle");
    // program masks while inactive, activate
    wrMasks(8'h01, 8'h1C, "R10_accept");
    wrStatus(1, 1, 0, 0, 0, 0, "R12_activate");
    // mask write while active is ignored
    wrMasks(8'hFF, 8'hFF, "R10_ignored");
    // plain split: start at 0, completes at 2,3,4, advance at 4
    ev(3'd0, "R8_start");
    ev(3'd1, "R9_no_cbit");
    ev(3'd2, "R9_cs");
    ev(3'd3, "R9_cs");
    ev(3'd4, "R9_last_advance");
    // I set mid-split
    ev(3'd0, "R8_start");
    wrStatus(0, 0, 0, 0, 1, 1, "R2_set_i");
    ev(3'd2, "R2_cs");
    ev(3'd3, "R2_cs");
    ev(3'd4, "R2_last_no_adv");
    ev(3'd5, "R3_retire_no_sbit");
    ev(3'd0, "R1_after_retire");
    // out-of-order reactivation: set Active while I set is refused
    wrStatus(1, 1, 1, 0, 0, 0, "R6_refused");
    wrStatus(0, 0, 0, 0, 1, 0, "R12_clear_i");
    wrStatus(0, 0, 1, 1, 0, 0, "R12_set_halted");
    ev(3'd0, "R1_halted_inactive");
    wrStatus(1, 1, 1, 0, 0, 0, "R12_reactivate");
    // I set in a scheduled start micro-frame
    wrStatus(0, 0, 0, 0, 1, 1, "R4_set_i");
    ev(3'd0, "R4_suppress_start");
    // reactivate in order, then halt blocks
    wrStatus(0, 0, 1, 1, 0, 0, "R12_halt");
    wrStatus(0, 0, 0, 0, 1, 0, "R12_clear_i");
    wrStatus(1, 1, 1, 0, 0, 0, "R12_set_active");
    wrStatus(0, 0, 1, 1, 0, 0, "R7_halt");
    ev(3'd0, "R7_blocked");
    wrStatus(0, 0, 1, 0, 0, 0, "R7_unhalt");
    ev(3'd0, "R8_start_again");
    // retire and same-cycle software set: retire wins
    wrStatus(0, 0, 0, 0, 1, 1, "R2_set_i");
    ev(3'd2, "R2_cs");
    ev(3'd3, "R2_cs");
    ev(3'd4, "R2_last");
    evalStb = 1; uFrame = 3'd0; swWrActive = 1; swActiveVal = 1;
    tick("R6_retire_wins");
    ev(3'd1, "R5_hold_wb");

    // random phase
    ufCnt = 0;
    for (int n = 0; n < 4000; n++) begin
      evalStb = ($urandom % 4) != 0;
      uFrame = ufCnt;
      if (evalStb) ufCnt = ufCnt + 1;
      swWrActive = ($urandom % 10) == 0; swActiveVal = $urandom % 2;
      swWrHalted = ($urandom % 12) == 0; swHaltedVal = ($urandom % 3) == 0;
      swWrInact  = ($urandom % 12) == 0; swInactVal = ($urandom % 3) == 0;
      swWrSMask  = ($urandom % 8) == 0;  swSMaskVal = 8'($urandom);
      swWrCMask  = ($urandom % 8) == 0;  swCMaskVal = 8'($urandom);
      tick("");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule